// File: doc/BRIEF.md
# Hierarchical USB Interrupt Aggregator

This block gathers the interrupt causes of a dual-role USB controller into one interrupt request line. Every device IN endpoint, every device OUT endpoint and every host channel owns a small status word. An event pulse sets a bit in that word and the bit stays set until a bus write of 1 to it clears it. Each status word is masked and OR-reduced to one summary bit per endpoint or channel. The device summaries share one word: IN endpoints fill its low half and OUT endpoints fill its high half. That word is gated by a device mask and folded into two core status bits. Host channel summaries are gated by a channel mask and folded into a third core bit. Port events latch directly into further core bits.

The core status word is ANDed with a core mask and OR-reduced. The result is then qualified by a global enable and registered onto `irq`. A mask only hides a pending cause and never removes it, so software clears a cause before it unmasks it. Every mask and clear goes through one write-only register bus. Addresses are 8 bits wide: bits [7:4] select a region and bits [3:0] select a register or an index.

Top module: `usb_irq_tree`

## Requirements
- R1: A one-cycle pulse on bit b of an IN endpoint's, OUT endpoint's or host channel's event input sets status bit b of that leaf at the next clock edge. The bit then stays set until it is cleared. Leaf k uses event bits [4k+3:4k].
- R2: A write to region 0x1 (IN), 0x2 (OUT) or 0x3 (channel status) at index k clears exactly those status bits of leaf k for which wr_data[3:0] is 1. Bits written as 0 keep their value.
- R3: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Address 0x03 holds the common IN mask (wr_data[3:0]) and address 0x04 holds the common OUT mask. Endpoint k's summary is the OR of its status ANDed with the matching common mask. It lands in bit k of the device word for IN endpoints and in bit 16+k for OUT endpoints. The device word is ANDed with the device mask at address 0x05. Any surviving low-half bit sets core bit 0, and any surviving high-half bit sets core bit 1.
- R5: Each host channel k has its own mask at address 0x4k (wr_data[3:0]). A channel's masked summary is gated by bit k of the all-channels mask at address 0x06, and any surviving channel sets core bit 2.
- R6: A pulse on port_evt[j] latches core bit 3+j. A write to address 0x01 clears the latched port bits for which wr_data[3:0] is 1. The same-cycle event-wins rule of R3 applies here too.
- R7: The core status is ANDed with the core mask at address 0x00 (wr_data[6:0]). Any surviving bit requests an interrupt.
- R8: Bit 0 of the configuration register at address 0x02 is a global enable. While it is 0, irq stays low.
- R9: Masking at any level leaves pending bits set. A cause that is pending while masked raises irq once it is unmasked, unless it was cleared first.
- R10: irq is registered. It reflects status and mask state as they stood before the previous clock edge.
- R11: Reset clears every status bit and every mask, and holds irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_ep_evt | input | 64 | IN endpoint event pulses, 4 per endpoint |
| out_ep_evt | input | 64 | OUT endpoint event pulses, 4 per endpoint |
| ch_evt | input | 64 | Host channel event pulses, 4 per channel |
| port_evt | input | 4 | Port event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address: region [7:4], index [3:0] |
| wr_data | input | 32 | Write data |
| irq | output | 1 | Registered interrupt request |

## Verification
The directed part drives one cause at a time through each branch of the tree: IN endpoint, OUT endpoint, host channel and port. Each cause is tried against every gate on its path. This shows which level blocks a cause and confirms that the IN and OUT halves of the device word are not swapped. Two patterns test the clear logic. A clear that coincides with an event separates event-wins from clear-wins. A partial clear of a two-bit status word shows that write-one-to-clear leaves the zero-written bits alone. Sequences that raise a cause while it is masked and unmask it later show that masks only hide pending bits. A long phase then mixes random event pulses with random mask writes and clears, compared every cycle against a behavioural model. That phase exposes interactions between levels and any off-by-one-cycle timing.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int IDX_W  = 4;
    localparam int RGN_W  = 4;
    localparam int ADDR_W = RGN_W + IDX_W;

    localparam logic [RGN_W-1:0] RGN_GLOBAL = 4'h0;
    localparam logic [RGN_W-1:0] RGN_IN_ST  = 4'h1;
    localparam logic [RGN_W-1:0] RGN_OUT_ST = 4'h2;
    localparam logic [RGN_W-1:0] RGN_CH_ST  = 4'h3;
    localparam logic [RGN_W-1:0] RGN_CH_MSK = 4'h4;

    localparam logic [IDX_W-1:0] OFS_CORE_MSK = 4'h0;
    localparam logic [IDX_W-1:0] OFS_CORE_CLR = 4'h1;
    localparam logic [IDX_W-1:0] OFS_CFG      = 4'h2;
    localparam logic [IDX_W-1:0] OFS_IN_CMSK  = 4'h3;
    localparam logic [IDX_W-1:0] OFS_OUT_CMSK = 4'h4;
    localparam logic [IDX_W-1:0] OFS_DEV_MSK  = 4'h5;
    localparam logic [IDX_W-1:0] OFS_CHALL    = 4'h6;

    localparam int CORE_FIXED = 3;
endpackage

// File: rtl/irq_leaf_bank.sv
module irq_leaf_bank
    import usb_irq_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N*W-1:0]     evt,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    input  logic [W-1:0]       clr_bits,
    input  logic [N*W-1:0]     eff_mask,
    output logic [N-1:0]       hit
);
    typedef struct packed {
        logic [N*W-1:0] st;
    } bank_s;

    bank_s          bank_d, bank_q;
    logic [N*W-1:0] clr_vec;

    always_comb begin
        clr_vec = '0;
        for (int i = 0; i < N; i++) begin
            if (clr_en && (clr_idx == IDX_W'(i)))
                clr_vec[i*W +: W] = clr_bits;
        end
        // event applied after clear: a coincident event wins
        bank_d.st = (bank_q.st & ~clr_vec) | evt;
        for (int i = 0; i < N; i++)
            hit[i] = |(bank_q.st[i*W +: W] & eff_mask[i*W +: W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    a_r1_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((bank_q.st & $past(evt)) == $past(evt)));

    a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((bank_q.st & $past(clr_vec & ~evt)) == '0));

    a_r1_only_event_or_clear_changes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((bank_q.st ^ $past(bank_q.st)) & ~$past(clr_vec | evt)) == '0));
endmodule

// File: rtl/irq_core.sv
module irq_core #(
    parameter int PORT_W = 4,
    parameter int CORE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_in_any,
    input  logic              dev_out_any,
    input  logic              host_any,
    input  logic [PORT_W-1:0] port_evt,
    input  logic              clr_en,
    input  logic [PORT_W-1:0] clr_bits,
    input  logic [CORE_W-1:0] core_mask,
    input  logic              glb_en,
    output logic              irq
);
    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              irq;
    } core_s;

    core_s             core_d, core_q;
    logic [PORT_W-1:0] clr_vec;
    logic [CORE_W-1:0] core_vec;

    always_comb begin
        clr_vec     = clr_en ? clr_bits : '0;
        core_vec    = {core_q.port, host_any, dev_out_any, dev_in_any};
        core_d.port = (core_q.port & ~clr_vec) | port_evt;
        core_d.irq  = glb_en & (|(core_vec & core_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign irq = core_q.irq;

    a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !irq);

    a_r7_core_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (core_mask == '0) |=> !irq);

    a_r6_port_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((core_q.port & $past(core_q.port & ~clr_vec)) == $past(core_q.port & ~clr_vec)));

    a_r6_port_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_evt) |=> ((core_q.port & $past(port_evt)) == $past(port_evt)));
endmodule

// File: rtl/usb_irq_tree.sv
module usb_irq_tree
    import usb_irq_pkg::*;
#(
    parameter int N_EP   = 16,
    parameter int N_CH   = 16,
    parameter int LEAF_W = 4,
    parameter int PORT_W = 4,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_EP*LEAF_W-1:0] in_ep_evt,
    input  logic [N_EP*LEAF_W-1:0] out_ep_evt,
    input  logic [N_CH*LEAF_W-1:0] ch_evt,
    input  logic [PORT_W-1:0]      port_evt,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    output logic                   irq
);
    localparam int DEV_W  = 2 * N_EP;
    localparam int CORE_W = CORE_FIXED + PORT_W;

    typedef struct packed {
        logic [CORE_W-1:0]      core_mask;
        logic                   glb_en;
        logic [LEAF_W-1:0]      in_cmask;
        logic [LEAF_W-1:0]      out_cmask;
        logic [DEV_W-1:0]       dev_mask;
        logic [N_CH-1:0]        ch_all_mask;
        logic [N_CH*LEAF_W-1:0] ch_mask;
    } cfg_s;

    cfg_s                   cfg_d, cfg_q;
    logic [RGN_W-1:0]       rgn;
    logic [IDX_W-1:0]       idx;
    logic                   in_clr, out_clr, ch_clr, core_clr;
    logic [N_EP*LEAF_W-1:0] in_eff, out_eff;
    logic [N_EP-1:0]        in_hit, out_hit;
    logic [N_CH-1:0]        ch_hit;
    logic [DEV_W-1:0]       dev_gated;
    logic                   in_any, out_any, host_any;

    always_comb begin
        rgn      = wr_addr[ADDR_W-1:IDX_W];
        idx      = wr_addr[IDX_W-1:0];
        in_clr   = wr_en && (rgn == RGN_IN_ST);
        out_clr  = wr_en && (rgn == RGN_OUT_ST);
        ch_clr   = wr_en && (rgn == RGN_CH_ST);
        core_clr = wr_en && (rgn == RGN_GLOBAL) && (idx == OFS_CORE_CLR);

        cfg_d = cfg_q;
        if (wr_en && rgn == RGN_GLOBAL) begin
            case (idx)
                OFS_CORE_MSK: cfg_d.core_mask   = wr_data[CORE_W-1:0];
                OFS_CFG:      cfg_d.glb_en      = wr_data[0];
                OFS_IN_CMSK:  cfg_d.in_cmask    = wr_data[LEAF_W-1:0];
                OFS_OUT_CMSK: cfg_d.out_cmask   = wr_data[LEAF_W-1:0];
                OFS_DEV_MSK:  cfg_d.dev_mask    = wr_data[DEV_W-1:0];
                OFS_CHALL:    cfg_d.ch_all_mask = wr_data[N_CH-1:0];
                default: ;
            endcase
        end
        if (wr_en && rgn == RGN_CH_MSK) begin
            for (int i = 0; i < N_CH; i++) begin
                if (idx == IDX_W'(i))
                    cfg_d.ch_mask[i*LEAF_W +: LEAF_W] = wr_data[LEAF_W-1:0];
            end
        end

        in_eff    = {N_EP{cfg_q.in_cmask}};
        out_eff   = {N_EP{cfg_q.out_cmask}};
        dev_gated = {out_hit, in_hit} & cfg_q.dev_mask;
        in_any    = |dev_gated[N_EP-1:0];
        out_any   = |dev_gated[DEV_W-1:N_EP];
        host_any  = |(ch_hit & cfg_q.ch_all_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    irq_leaf_bank #(.N(N_EP), .W(LEAF_W)) u_in_bank (
        .clk(clk), .rst_n(rst_n), .evt(in_ep_evt),
        .clr_en(in_clr), .clr_idx(idx), .clr_bits(wr_data[LEAF_W-1:0]),
        .eff_mask(in_eff), .hit(in_hit));

    irq_leaf_bank #(.N(N_EP), .W(LEAF_W)) u_out_bank (
        .clk(clk), .rst_n(rst_n), .evt(out_ep_evt),
        .clr_en(out_clr), .clr_idx(idx), .clr_bits(wr_data[LEAF_W-1:0]),
        .eff_mask(out_eff), .hit(out_hit));

    irq_leaf_bank #(.N(N_CH), .W(LEAF_W)) u_ch_bank (
        .clk(clk), .rst_n(rst_n), .evt(ch_evt),
        .clr_en(ch_clr), .clr_idx(idx), .clr_bits(wr_data[LEAF_W-1:0]),
        .eff_mask(cfg_q.ch_mask), .hit(ch_hit));

    irq_core #(.PORT_W(PORT_W), .CORE_W(CORE_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .dev_in_any(in_any), .dev_out_any(out_any), .host_any(host_any),
        .port_evt(port_evt), .clr_en(core_clr), .clr_bits(wr_data[PORT_W-1:0]),
        .core_mask(cfg_q.core_mask), .glb_en(cfg_q.glb_en), .irq(irq));

    // R4: device summary gating, high half must stay silent while its mask half is zero
    a_r4_out_half_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.dev_mask[DEV_W-1:N_EP] == '0) |-> !out_any);

    // R5: host branch silent while no channel is enabled at the all-channels level
    a_r5_host_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ch_all_mask == '0) |-> !host_any);
endmodule

// File: tb/usb_irq_tree_test.sv
`timescale 1ns/1ps
module usb_irq_tree_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] in_ep_evt = '0, out_ep_evt = '0, ch_evt = '0;
    logic [3:0]  port_evt = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    usb_irq_tree uut (
        .clk(clk), .rst_n(rst_n), .in_ep_evt(in_ep_evt), .out_ep_evt(out_ep_evt),
        .ch_evt(ch_evt), .port_evt(port_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq(irq));

    // behavioural reference state
    int unsigned m_in[16], m_out[16], m_ch[16], m_chm[16];
    int unsigned m_in_cm, m_out_cm, m_dev, m_chall, m_core, m_glb, m_port;
    bit exp_irq;

    function automatic bit model_irq();
        bit a_in = 0, a_out = 0, a_ch = 0;
        int unsigned core;
        for (int i = 0; i < 16; i++) begin
            if (((m_in[i] & m_in_cm) != 0) && m_dev[i]) a_in = 1;
            if (((m_out[i] & m_out_cm) != 0) && m_dev[16+i]) a_out = 1;
            if (((m_ch[i] & m_chm[i]) != 0) && m_chall[i]) a_ch = 1;
        end
        core = (m_port << 3) | (int'(a_ch) << 2) | (int'(a_out) << 1) | int'(a_in);
        return (m_glb != 0) && ((core & m_core) != 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_in[i] = 0; m_out[i] = 0; m_ch[i] = 0; m_chm[i] = 0;
            end
            m_in_cm = 0; m_out_cm = 0; m_dev = 0; m_chall = 0;
            m_core = 0; m_glb = 0; m_port = 0; exp_irq = 0;
        end else begin
            int unsigned rg, ix, d4;
            exp_irq = model_irq();
            rg = wr_addr[7:4]; ix = wr_addr[3:0]; d4 = wr_data[3:0];
            if (wr_en) begin
                case (rg)
                    0: case (ix)
                        0: m_core = wr_data[6:0];
                        1: m_port = m_port & ~d4;
                        2: m_glb = wr_data[0];
                        3: m_in_cm = d4;
                        4: m_out_cm = d4;
                        5: m_dev = wr_data;
                        6: m_chall = wr_data[15:0];
                        default: ;
                       endcase
                    1: m_in[ix] = m_in[ix] & ~d4;
                    2: m_out[ix] = m_out[ix] & ~d4;
                    3: m_ch[ix] = m_ch[ix] & ~d4;
                    4: m_chm[ix] = d4;
                    default: ;
                endcase
            end
            for (int i = 0; i < 16; i++) begin
                m_in[i]  = m_in[i]  | in_ep_evt[i*4 +: 4];
                m_out[i] = m_out[i] | out_ep_evt[i*4 +: 4];
                m_ch[i]  = m_ch[i]  | ch_evt[i*4 +: 4];
            end
            m_port = m_port | port_evt;
        end
    end

    task automatic chk(input bit got, input bit exp, input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: irq=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // R10: cycle-accurate comparison against the model
    always @(negedge clk) begin
        if (rst_n && model_on) chk(irq, exp_irq, "R10 per-cycle model");
    end

    task automatic step(); @(negedge clk); endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic ev_in(input int ep, input logic [3:0] b);
        in_ep_evt[ep*4 +: 4] = b; step(); in_ep_evt = '0;
    endtask
    task automatic ev_out(input int ep, input logic [3:0] b);
        out_ep_evt[ep*4 +: 4] = b; step(); out_ep_evt = '0;
    endtask
    task automatic ev_ch(input int c, input logic [3:0] b);
        ch_evt[c*4 +: 4] = b; step(); ch_evt = '0;
    endtask
    task automatic ev_port(input logic [3:0] b);
        port_evt = b; step(); port_evt = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog: run did not complete");
        summary();
        $finish;
    end

    initial begin
        repeat (3) step();
        chk(irq, 1'b0, "R11 reset holds irq low");
        rst_n = 1'b1;
        model_on = 1'b1;
        step();
        chk(irq, 1'b0, "R11 masks zero after reset");

        wr(8'h02, 32'h1);
        wr(8'h00, 32'h7F);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h03, 32'hF);

        // R1 / R10
        ev_in(3, 4'b0010);
        chk(irq, 1'b0, "R10 no irq in the cycle after the pulse edge");
        step();
        chk(irq, 1'b1, "R1 R4 IN event raises irq");
        repeat (3) step();
        chk(irq, 1'b1, "R1 status holds");

        // R2 clear
        wr(8'h13, 32'h2);
        chk(irq, 1'b1, "R10 irq lags clear by one cycle");
        step();
        chk(irq, 1'b0, "R2 write-one clears");

        // R3 event wins
        in_ep_evt[3*4 +: 4] = 4'b0001;
        wr_en = 1'b1; wr_addr = 8'h13; wr_data = 32'h1;
        step();
        in_ep_evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        step();
        chk(irq, 1'b1, "R3 event wins over clear");
        wr(8'h13, 32'h1); step();
        chk(irq, 1'b0, "R3 cleanup");

        // R2 partial clear
        ev_in(3, 4'b0110);
        wr(8'h13, 32'h2); step();
        chk(irq, 1'b1, "R2 zero-written bit kept");
        wr(8'h13, 32'h4); step();
        chk(irq, 1'b0, "R2 last bit cleared");

        // R9 / R4 OUT half
        ev_out(5, 4'b0100); step();
        chk(irq, 1'b0, "R9 masked OUT cause hidden");
        wr(8'h04, 32'h4); step();
        chk(irq, 1'b1, "R9 R4 visible on unmask");
        wr(8'h05, ~(32'h1 << 21)); step();
        chk(irq, 1'b0, "R4 device mask bit 21 gates OUT ep 5");
        ev_in(5, 4'b0001); step();
        chk(irq, 1'b1, "R4 IN ep 5 uses bit 5 not bit 21");
        wr(8'h15, 32'h1); wr(8'h25, 32'h4); wr(8'h05, 32'hFFFF_FFFF); step();
        chk(irq, 1'b0, "R4 cleanup");

        // R5 host channel
        ev_ch(7, 4'b1000); step();
        chk(irq, 1'b0, "R5 channel mask zero");
        wr(8'h47, 32'h8); step();
        chk(irq, 1'b0, "R5 all-channels mask zero");
        wr(8'h06, 32'h1 << 7); step();
        chk(irq, 1'b1, "R5 channel 7 visible");
        wr(8'h37, 32'h8); step();
        chk(irq, 1'b0, "R5 channel cleared");

        // R6 port
        ev_port(4'b0100); step();
        chk(irq, 1'b1, "R6 port event latched");
        repeat (3) step();
        chk(irq, 1'b1, "R6 port bit sticky");
        wr(8'h01, 32'h4); step();
        chk(irq, 1'b0, "R6 port bit cleared");

        // R7 core mask
        wr(8'h00, 32'h1 << 5);
        ev_in(1, 4'b0001); step();
        chk(irq, 1'b0, "R7 core bit 0 masked");
        ev_port(4'b0100); step();
        chk(irq, 1'b1, "R7 core bit 5 passes");
        wr(8'h01, 32'h4); wr(8'h11, 32'h1); wr(8'h00, 32'h7F);

        // R8 global enable
        wr(8'h02, 32'h0);
        ev_port(4'b0001); step();
        chk(irq, 1'b0, "R8 global enable off");
        wr(8'h02, 32'h1); step();
        chk(irq, 1'b1, "R8 R9 global enable on");
        wr(8'h01, 32'h1); step();
        chk(irq, 1'b0, "R8 cleanup");

        // mixed random traffic, checked every cycle by the model
        for (int n = 0; n < 4000; n++) begin
            in_ep_evt  = ($urandom % 6 == 0) ? (64'h1 << ($urandom % 64)) : '0;
            out_ep_evt = ($urandom % 6 == 0) ? (64'h1 << ($urandom % 64)) : '0;
            ch_evt     = ($urandom % 6 == 0) ? (64'h1 << ($urandom % 64)) : '0;
            port_evt   = ($urandom % 10 == 0) ? 4'($urandom) : '0;
            wr_en      = ($urandom % 2 == 0);
            wr_addr    = {4'($urandom % 5), 4'($urandom)};
            wr_data    = $urandom;
            if (wr_addr == 8'h02) wr_data[0] = ($urandom % 4 != 0);
            step();
        end
        in_ep_evt = '0; out_ep_evt = '0; ch_evt = '0; port_evt = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (4) step();

        summary();
        $finish;
    end
endmodule